// File: doc/BRIEF.md
# Run-time reconfigurable distributed-arithmetic FIR filter

This block is a 20-tap FIR filter that contains no coefficient multipliers. It keeps the 20 most recent input samples in a delay line and walks through them one bit per clock. The least significant bit comes first and the sign bit comes last. In each bit cycle the block forms a 5-bit address from one bit of each of five taps. It does this for each of four groups. Each address picks a precomputed partial product from that group's 32-entry table. The four partial products are summed and added into a shifting accumulator. In the sign-bit cycle the sum is subtracted instead of added. One sample therefore takes 8 clocks, and the result comes out with a single-cycle valid strobe.

Four filter responses are available:

| Code | Response |
|------|----------|
| 0 | low-pass |
| 1 | high-pass |
| 2 | band-pass |
| 3 | band-stop |

The block switches between them only by overwriting the table contents. The datapath itself never changes. A host, for example a processor driving general-purpose pins, sets the response code and pulses a request. An internal ROM supplies the precomputed tables. The block copies them, one table entry per clock, over 128 cycles. It raises a busy flag for the whole copy and pulses a done flag at the end. Coming out of reset, the block loads the low-pass set by itself.

Top module: `da_fir_recfg`

## Requirements
- R1: After reset is released, `busy` stays high for exactly 128 cycles while the low-pass set (code 0) loads. `done` is then high for one cycle, in the cycle where `busy` has just fallen. During reset and the load, `out_valid` is low.
- R2: Tap `t` (0 = newest sample) carries a coefficient built in four steps:
  - Let `d = min(t, 19-t)`.
  - Let `b = 4*(d+1)`.
  - Set the sign by response code: code 0 is always `+b`; code 1 is `+b` for even `t` and `-b` for odd `t`; code 2 is `+b` when `t mod 4` is 0 or 1 and `-b` otherwise; code 3 is `+b` when `t mod 4` is 0 or 3 and `-b` otherwise.
  - Each result is `out_data` = the sum over `t` of coefficient(t) × x[t], over the last 20 accepted samples, with unfilled taps counted as zero.
- R3: A sample is accepted when `in_valid` is high at a clock edge and the block is idle. Its result appears with `out_valid` high for exactly one cycle. That cycle follows the 8th clock edge after the accepting edge. `out_data` keeps that value afterwards.
- R4: `in_sample` is 8-bit two's complement. The extreme values -128 and 127 give exact results.
- R5: If `cfg_req` is high at an edge where `busy` is low, the block does four things: it latches `mode_sel` as the new response code, clears the sample history, holds `busy` high for exactly 128 cycles, and pulses `done` once at the end.
- R6: A `cfg_req` that arrives while `busy` is high is ignored. The response code stays the same and the load is not lengthened.
- R7: Samples presented while `busy` is high are dropped. `out_valid` stays low while `busy` is high.
- R8: A sample presented at any edge from the accepting edge up to and including the 8th edge after it is dropped. It does not enter the history.
- R9: A `cfg_req` accepted while a sample is still being processed cancels that computation. No `out_valid` is produced for that sample.
- R10: After a reload, an all-zero history gives `out_data` = 0. Table entry 0 holds zero in every table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 8 | Signed input sample |
| mode_sel | input | 2 | Response code for the next reload |
| cfg_req | input | 1 | Reload request |
| busy | output | 1 | Table reload in progress |
| done | output | 1 | One-cycle pulse at the end of a reload |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 26 | Signed filter result |

## Verification
Each response is driven with several input patterns, and each one exposes a different kind of fault:
- A unit impulse followed by zeros reads back the coefficients one tap at a time. It exposes wrong table contents or a wrong group-to-tap mapping.
- Full-scale +127 and -128 samples, together with -1 and alternating ±100 sequences, exercise the sign-bit subtraction and the shift arithmetic. Low-order errors and sign errors show up there.

A sequence of two distinct samples checked under codes 1 and 2 separates a reload that honoured a second request from one that correctly ignored it. Samples injected during a load or a computation, and a request made partway through a computation, show whether the dropping and cancelling rules hold.

// File: rtl/da_fir_recfg.sv
module da_fir_recfg #(
  parameter int TAPS = 20,
  parameter int GRP  = 5,
  parameter int DW   = 8,
  parameter int PW   = 16,
  parameter int OW   = PW + DW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_sample,
  input  logic [1:0]    mode_sel,
  input  logic          cfg_req,
  output logic          busy,
  output logic          done,
  output logic          out_valid,
  output logic [OW-1:0] out_data
);
  localparam int NG  = TAPS / GRP;
  localparam int ENT = 1 << GRP;
  localparam int NLD = NG * ENT;
  localparam int LW  = $clog2(NLD);
  localparam int GW  = $clog2(NG);
  localparam int BW  = $clog2(DW);
  localparam int SW  = PW + GW + 1;
  localparam int AW  = SW + DW + 1;
  localparam logic [BW-1:0] LASTB = BW'(DW - 1);
  localparam logic [LW-1:0] LASTI = LW'(NLD - 1);

  function automatic logic signed [PW-1:0] coef(input logic [1:0] m, input int t);
    int d, b, v;
    d = (t < TAPS - 1 - t) ? t : TAPS - 1 - t;
    b = 4 * (d + 1);
    case (m)
      2'd0: v = b;
      2'd1: v = (t % 2 == 0) ? b : -b;
      2'd2: v = (t % 4 < 2) ? b : -b;
      default: v = (t % 4 == 0 || t % 4 == 3) ? b : -b;
    endcase
    return v[PW-1:0];
  endfunction

  function automatic logic signed [PW-1:0] pp(input logic [1:0] m, input int g,
                                              input logic [GRP-1:0] k);
    logic signed [PW-1:0] s;
    s = '0;
    for (int i = 0; i < GRP; i++)
      if (k[i]) s = s + coef(m, g * GRP + i);
    return s;
  endfunction

  logic [DW-1:0]        xs  [TAPS];
  logic signed [PW-1:0] lut [NG][ENT];
  logic [LW-1:0]        ld_idx;
  logic [1:0]           ld_mode;
  logic [BW-1:0]        bit_n;
  logic                 run;
  logic signed [AW-1:0] acc, acc_nx, term_w;
  logic signed [SW-1:0] tsum, term;
  logic [GRP-1:0]       addr [NG];
  logic [GW-1:0]        ld_g;
  logic [GRP-1:0]       ld_e;

  assign ld_g = ld_idx[LW-1:GRP];
  assign ld_e = ld_idx[GRP-1:0];

  always_comb begin
    tsum = '0;
    for (int g = 0; g < NG; g++) begin
      for (int i = 0; i < GRP; i++) addr[g][i] = xs[g*GRP+i][bit_n];
      tsum = tsum + SW'(lut[g][addr[g]]);
    end
  end

  assign term   = (bit_n == LASTB) ? -tsum : tsum;
  assign term_w = AW'(term);
  assign acc_nx = (acc + (term_w <<< DW)) >>> 1;

  always_ff @(posedge clk) begin
    if (busy) lut[ld_g][ld_e] <= pp(ld_mode, int'(ld_g), ld_e);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b1;
      done      <= 1'b0;
      ld_idx    <= '0;
      ld_mode   <= 2'd0;
      run       <= 1'b0;
      bit_n     <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int t = 0; t < TAPS; t++) xs[t] <= '0;
    end else begin
      done      <= 1'b0;
      out_valid <= 1'b0;
      if (busy) begin
        ld_idx <= ld_idx + 1'b1;
        if (ld_idx == LASTI) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (cfg_req) begin
        busy    <= 1'b1;
        ld_idx  <= '0;
        ld_mode <= mode_sel;
        run     <= 1'b0;
        for (int t = 0; t < TAPS; t++) xs[t] <= '0;
      end else if (run) begin
        acc   <= acc_nx;
        bit_n <= bit_n + 1'b1;
        if (bit_n == LASTB) begin
          run       <= 1'b0;
          out_valid <= 1'b1;
          out_data  <= acc_nx[OW-1:0];
        end
      end else if (in_valid) begin
        for (int t = TAPS - 1; t > 0; t--) xs[t] <= xs[t-1];
        xs[0] <= in_sample;
        run   <= 1'b1;
        bit_n <= '0;
        acc   <= '0;
      end
    end
  end
endmodule

// File: rtl/da_fir_recfg_chk.sv
module da_fir_recfg_chk #(
  parameter int LOADS = 128
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic out_valid,
  input logic cfg_req
);
  localparam int CW = $clog2(LOADS + 1) + 1;
  logic [CW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else        bcnt <= busy ? bcnt + 1'b1 : '0;
  end

  AST_DONE_AFTER_FULL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && bcnt == CW'(LOADS))); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R1
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !out_valid); // R7
  AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R3
  AST_REQ_STARTS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cfg_req) |=> busy); // R5
  AST_LOAD_NOT_EXTENDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt < CW'(LOADS)); // R6
endmodule

bind da_fir_recfg da_fir_recfg_chk #(.LOADS(NLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .out_valid(out_valid), .cfg_req(cfg_req)
);

// File: tb/sim_da_fir_recfg.sv
module sim_da_fir_recfg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_sample = '0;
  logic [1:0]  mode_sel = '0;
  logic        cfg_req = 1'b0;
  logic        busy, done, out_valid;
  logic [25:0] out_data;

  int checks = 0;
  int errs = 0;
  int cur_mode = 0;
  longint hist [20];

  always #4 clk = ~clk;

  da_fir_recfg u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
                   .mode_sel(mode_sel), .cfg_req(cfg_req), .busy(busy), .done(done),
                   .out_valid(out_valid), .out_data(out_data));

  // {reload, code[1:0], sample[7:0]}
  localparam logic [10:0] VEC [24] = '{
    {1'b0, 2'd0, 8'd1},   {1'b0, 2'd0, 8'd0},   {1'b0, 2'd0, 8'd0},   {1'b0, 2'd0, 8'd0},
    {1'b0, 2'd0, 8'd127}, {1'b0, 2'd0, 8'h80},  {1'b0, 2'd0, 8'hFF},  {1'b0, 2'd0, 8'd55},
    {1'b1, 2'd1, 8'd1},   {1'b0, 2'd1, 8'h80},  {1'b0, 2'd1, 8'd127}, {1'b0, 2'd1, 8'hC3},
    {1'b1, 2'd2, 8'd100}, {1'b0, 2'd2, 8'h9C},  {1'b0, 2'd2, 8'd100}, {1'b0, 2'd2, 8'h9C},
    {1'b1, 2'd3, 8'd7},   {1'b0, 2'd3, 8'd127}, {1'b0, 2'd3, 8'd127}, {1'b0, 2'd3, 8'd127},
    {1'b0, 2'd3, 8'h80},  {1'b0, 2'd3, 8'd3},   {1'b1, 2'd0, 8'h81},  {1'b0, 2'd0, 8'd64}
  };

  function automatic longint cf(int m, int t);
    int d, b;
    d = (t < 19 - t) ? t : 19 - t;
    b = 4 * (d + 1);
    if (m == 1) return (t % 2 == 0) ? b : -b;
    if (m == 2) return (t % 4 < 2) ? b : -b;
    if (m == 3) return (t % 4 == 0 || t % 4 == 3) ? b : -b;
    return b;
  endfunction

  function automatic longint ref_y();
    longint s = 0;
    for (int t = 0; t < 20; t++) s += cf(cur_mode, t) * hist[t];
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
  endtask

  task automatic wait_load(input string req, input bit inject_req, input bit inject_smp);
    int n = 0;
    int ov = 0;
    while (busy && n < 400) begin
      n++;
      if (out_valid) ov++;
      if (n == 20 && inject_req) begin mode_sel = 2'd2; cfg_req = 1'b1; end
      if (n == 30 && inject_smp) begin in_sample = 8'd99; in_valid = 1'b1; end
      @(negedge clk);
      cfg_req = 1'b0;
      in_valid = 1'b0;
    end
    chk(n == 128, {req, " busy length"}, n, 128);
    chk(done == 1'b1, {req, " done at end"}, done, 1);
    chk(ov == 0, "R7 out_valid during busy", ov, 0);
    @(negedge clk);
    chk(done == 1'b0, {req, " done single"}, done, 0);
  endtask

  task automatic reload(input int m, input bit inject_req, input bit inject_smp);
    @(negedge clk);
    mode_sel = 2'(m);
    cfg_req = 1'b1;
    @(negedge clk);
    cfg_req = 1'b0;
    wait_load("R5", inject_req, inject_smp);
    cur_mode = m;
    for (int t = 0; t < 20; t++) hist[t] = 0;
  endtask

  task automatic send(input logic [7:0] s, input string req, input int extra_at);
    int n = 0;
    longint e;
    @(negedge clk);
    in_sample = s;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int t = 19; t > 0; t--) hist[t] = hist[t-1];
    hist[0] = longint'($signed(s));
    e = ref_y();
    while (!out_valid && n < 30) begin
      @(negedge clk);
      n++;
      if (n == extra_at) begin in_sample = 8'h55; in_valid = 1'b1; end
      else in_valid = 1'b0;
    end
    in_valid = 1'b0;
    chk(n == 8, "R3 latency", n, 8);
    chk(longint'($signed(out_data)) == e, req, longint'($signed(out_data)), e);
    @(negedge clk);
    chk(!out_valid && longint'($signed(out_data)) == e, "R3 single pulse and hold",
        out_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL timeout actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int t = 0; t < 20; t++) hist[t] = 0;
    repeat (3) @(negedge clk);
    chk(busy && !out_valid && !done, "R1 reset state", {busy, out_valid, done}, 3'b100);
    rst_n = 1'b1;
    wait_load("R1", 1'b0, 1'b0);

    for (int v = 0; v < 24; v++) begin
      if (VEC[v][10]) reload(int'(VEC[v][9:8]), 1'b0, 1'b0);
      send(VEC[v][7:0], "R2 R4 filter output", 0);
    end

    reload(1, 1'b1, 1'b1);               // R6 second request, R7 sample dropped
    send(8'd5, "R6 R7 output after ignored request", 0);
    send(8'hFD, "R6 code kept", 0);

    send(8'd9, "R8 first sample", 3);    // R8 extra sample 3 edges later
    send(8'd11, "R8 dropped sample absent", 8);

    @(negedge clk);
    in_sample = 8'd77; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    reload(3, 1'b0, 1'b0);               // R9 cancels computation (checked in wait_load)
    send(8'd0, "R10 zero history gives zero", 0);
    send(8'd2, "R9 history cleared after cancel", 0);

    summary();
    $finish;
  end
endmodule